// File: doc/BRIEF.md
# Sample-Counting Serial Receiver with Bit Reliability Flags

This block receives asynchronous serial characters and is paced by a single-cycle clock enable that runs at sixteen times the bit rate. It does not take one sample in the middle of each bit. Instead it counts how many of a bit's sample periods see the line high, and the top bit of that count gives the bit's value. A count close to half marks the bit as questionable. When parity is on, the parity check fails and exactly one bit is questionable, that bit is inverted and the character is reported as repaired.

The line passes through a synchronizer before any counting. A configuration chosen at the start of each frame sets the word length (5 to 8 bits), whether a parity bit is present, whether parity is odd or even, and whether the frame has one or two stop bits. Each received character is presented with a one-clock valid strobe. The data byte, the error flags and the per-bit reliability mask come with the strobe and keep their values until the next character.

Top module: `vote_uart_rx`

## Requirements
- R1: On a tick in idle where the synchronized line is low and the previous idle tick saw it high, a frame begins, and that tick is sample 0 of the start bit. If the line is high at sample 7 (the 8th tick), the frame is dropped without a valid strobe and the receiver returns to idle.
- R2: Each frame bit lasts 16 ticks (samples 0..15). The bit decides as 1 when 8 or more of samples 0..14 were high. Sample 15 is never counted.
- R3: A bit is flagged as questionable when its high count is 6, 7, 8 or 9. In `q_mask`, bit i holds the flag of data bit i and bit 8 holds the flag of the parity bit. Bit 8 is 0 when parity is off, and mask bits above the word length are 0.
- R4: Data arrives least significant bit first. `cfg_wlen` 00/01/10/11 selects 5/6/7/8 data bits, the word is right-aligned in `rx_data`, and the unused upper bits are 0.
- R5: With `cfg_par_en` set, the XOR of the decided data bits and the parity bit must equal `cfg_par_odd` (1 = odd, 0 = even). `parity_err` is set when this fails and the number of flagged data and parity bits is not exactly one.
- R6: When the parity check fails and exactly one data or parity bit is flagged, that bit is inverted (a flagged parity bit leaves the data unchanged), `corrected` is set and `parity_err` is clear.
- R7: After the data bits and the optional parity bit come one stop bit, or two when `cfg_two_stop` is set. `frame_err` is set when any stop bit decides as 0.
- R8: `rx_valid` is high for exactly one clock, in the cycle after the clock edge that takes the last tick of the final stop bit. The outputs keep their values until the next strobe. The configuration is captured when the frame begins.
- R9: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial line, high when idle |
| tick16 | input | 1 | Single-cycle enable at 16x the bit rate |
| cfg_wlen | input | 2 | Word length: 5 + value data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | Two stop bits when set |
| rx_data | output | 8 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock character strobe |
| frame_err | output | 1 | A stop bit decided as 0 |
| parity_err | output | 1 | Parity failure that could not be repaired |
| corrected | output | 1 | A single flagged bit was inverted |
| q_mask | output | 9 | Questionable-bit flags: data bits [7:0], parity bit [8] |

## Verification
On every cycle the assertions check that the strobe is a single cycle that follows the end of a bit period, and that a start bit seen high at its midpoint ends the frame. At each strobe they also check that repair and parity error never appear together, that a repair always comes with exactly one flagged bit, that no parity flag appears when parity is off, and that data above the latched word length is zero. Only the bench's scenarios can show the counting decision and its exact thresholds (counts of 5 to 10 and an excluded high 16th sample), least-significant-first ordering across all word lengths, which bit the repair inverts, and framing errors on either stop bit. This is done by comparing whole characters against a model built from the requirements.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int CNT_W    = 4;
  localparam int SLOTS    = 1 << CNT_W;
  localparam int DATA_MAX = 8;
  localparam int MASK_W   = DATA_MAX + 1;
  localparam int IDX_W    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rx_state_e;

  typedef struct packed {
    logic [DATA_MAX-1:0] data;
    logic                perr;
    logic                corr;
  } fix_t;

  // top bit of the high-sample count is the decided value
  function automatic logic bit_decide(input logic [CNT_W-1:0] c);
    return c[CNT_W-1];
  endfunction

  // counts whose upper bits sit just below or at half are questionable
  function automatic logic bit_marginal(input logic [CNT_W-1:0] c);
    logic [CNT_W-2:0] hi;
    hi = c[CNT_W-1:1];
    return (hi == (CNT_W-1)'(SLOTS/4 - 1)) || (hi == (CNT_W-1)'(SLOTS/4));
  endfunction

  function automatic logic [IDX_W-1:0] word_bits(input logic [1:0] wl);
    return IDX_W'(5) + {2'b00, wl};
  endfunction

  function automatic fix_t parity_fix(input logic [DATA_MAX-1:0] d,
                                      input logic pbit,
                                      input logic [MASK_W-1:0] m,
                                      input logic pen,
                                      input logic odd);
    fix_t r;
    r.data = d;
    r.perr = 1'b0;
    r.corr = 1'b0;
    if (pen && ((^d ^ pbit) != odd)) begin
      if ($countones(m) == 1) begin
        r.corr = 1'b1;
        if (!m[MASK_W-1]) r.data = d ^ m[DATA_MAX-1:0];
      end else begin
        r.perr = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vrx_sync.sv
module vrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vrx_bit_timer.sv
module vrx_bit_timer
  import vrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic start,
  input  logic rx_s,
  output logic mid_tick,
  output logic end_tick,
  output logic bit_val,
  output logic bit_flag
);
  localparam logic [CNT_W-1:0] MID  = (CNT_W)'(SLOTS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = (CNT_W)'(SLOTS - 1);

  logic [CNT_W-1:0] pc;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      cnt <= '0;
    end else if (start) begin
      pc  <= (CNT_W)'(1);
      cnt <= '0;
    end else if (!busy) begin
      pc  <= '0;
      cnt <= '0;
    end else if (tick) begin
      pc <= pc + 1'b1;
      if (pc == LAST)  cnt <= '0;
      else if (rx_s)   cnt <= cnt + 1'b1;
    end
  end

  assign mid_tick = busy && tick && (pc == MID);
  assign end_tick = busy && tick && (pc == LAST);
  assign bit_val  = bit_decide(cnt);
  assign bit_flag = bit_marginal(cnt);
endmodule

// File: rtl/vrx_framer.sv
module vrx_framer
  import vrx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_s,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                mid_tick,
  input  logic                end_tick,
  input  logic                bit_val,
  input  logic                bit_flag,
  output logic                start,
  output logic                busy,
  output logic                in_start,
  output logic [IDX_W-1:0]    lat_nbits,
  output logic                lat_par_en,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                frame_err,
  output logic                parity_err,
  output logic                corrected,
  output logic [MASK_W-1:0]   q_mask
);
  rx_state_e           state;
  logic                prev_hi;
  logic [IDX_W-1:0]    idx;
  logic                odd_q, two_q;
  logic [DATA_MAX-1:0] dat_q;
  logic                pbit_q;
  logic [MASK_W-1:0]   mask_q;
  logic                ferr_q;
  logic [IDX_W-1:0]    last_idx;
  fix_t                fix;

  assign busy     = (state != ST_IDLE);
  assign in_start = (state == ST_START);
  assign start    = (state == ST_IDLE) && tick && !rx_s && prev_hi;
  assign last_idx = lat_nbits + {{(IDX_W-1){1'b0}}, lat_par_en} + {{(IDX_W-1){1'b0}}, two_q};
  assign fix      = parity_fix(dat_q, pbit_q, mask_q, lat_par_en, odd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      prev_hi    <= 1'b0;
      idx        <= '0;
      lat_nbits  <= '0;
      lat_par_en <= 1'b0;
      odd_q      <= 1'b0;
      two_q      <= 1'b0;
      dat_q      <= '0;
      pbit_q     <= 1'b0;
      mask_q     <= '0;
      ferr_q     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
      corrected  <= 1'b0;
      q_mask     <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (tick) prev_hi <= rx_s;
          if (start) begin
            state      <= ST_START;
            lat_nbits  <= word_bits(cfg_wlen);
            lat_par_en <= cfg_par_en;
            odd_q      <= cfg_par_odd;
            two_q      <= cfg_two_stop;
          end
        end
        ST_START: begin
          if (mid_tick && rx_s) begin
            state   <= ST_IDLE;
            prev_hi <= 1'b0;
          end else if (end_tick) begin
            state  <= ST_BITS;
            idx    <= '0;
            dat_q  <= '0;
            pbit_q <= 1'b0;
            mask_q <= '0;
            ferr_q <= 1'b0;
          end
        end
        ST_BITS: begin
          if (end_tick) begin
            idx <= idx + 1'b1;
            if (idx < lat_nbits) begin
              dat_q[idx[2:0]]  <= bit_val;
              mask_q[idx[2:0]] <= bit_flag;
            end else if (lat_par_en && (idx == lat_nbits)) begin
              pbit_q           <= bit_val;
              mask_q[MASK_W-1] <= bit_flag;
            end else if (!bit_val) begin
              ferr_q <= 1'b1;
            end
            if (idx == last_idx) begin
              state      <= ST_IDLE;
              prev_hi    <= 1'b0;
              rx_valid   <= 1'b1;
              rx_data    <= fix.data;
              parity_err <= fix.perr;
              corrected  <= fix.corr;
              q_mask     <= mask_q;
              frame_err  <= ferr_q | !bit_val;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vote_uart_rx.sv
module vote_uart_rx
  import vrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                tick16,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                frame_err,
  output logic                parity_err,
  output logic                corrected,
  output logic [MASK_W-1:0]   q_mask
);
  logic             rx_s;
  logic             start, busy, in_start;
  logic             mid_tick, end_tick;
  logic             bit_val, bit_flag;
  logic [IDX_W-1:0] lat_nbits;
  logic             lat_par_en;

  vrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  vrx_bit_timer timer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .busy(busy), .start(start),
    .rx_s(rx_s), .mid_tick(mid_tick), .end_tick(end_tick),
    .bit_val(bit_val), .bit_flag(bit_flag)
  );

  vrx_framer framer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .mid_tick(mid_tick), .end_tick(end_tick),
    .bit_val(bit_val), .bit_flag(bit_flag), .start(start), .busy(busy),
    .in_start(in_start), .lat_nbits(lat_nbits), .lat_par_en(lat_par_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err), .corrected(corrected), .q_mask(q_mask)
  );
endmodule

// File: rtl/vote_uart_rx_chk.sv
module vote_uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_s,
  input logic       busy,
  input logic       in_start,
  input logic       mid_tick,
  input logic       end_tick,
  input logic [3:0] lat_nbits,
  input logic       lat_par_en,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       parity_err,
  input logic       corrected,
  input logic [8:0] q_mask
);
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(end_tick));

  a_r1_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && mid_tick && rx_s) |=> !busy);

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && corrected) |-> ($countones(q_mask) == 1));

  a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(parity_err && corrected));

  a_r3_no_par_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !lat_par_en) |-> !q_mask[8]);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> lat_nbits) == 8'd0));
endmodule

bind vote_uart_rx vote_uart_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .busy(busy), .in_start(in_start),
  .mid_tick(mid_tick), .end_tick(end_tick), .lat_nbits(lat_nbits),
  .lat_par_en(lat_par_en), .rx_data(rx_data), .rx_valid(rx_valid),
  .parity_err(parity_err), .corrected(corrected), .q_mask(q_mask)
);

// File: tb/vote_uart_rx_tb_top.sv
module vote_uart_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err, corrected;
  logic [8:0] q_mask;

  int n_chk = 0;
  int n_bad = 0;
  int vcount = 0;
  int hcnt[12];
  bit s15[12];

  always #10 clk = ~clk;

  vote_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_err(frame_err), .parity_err(parity_err), .corrected(corrected),
    .q_mask(q_mask)
  );

  always @(negedge clk) if (rx_valid) vcount++;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tk(input bit v);
    rx_line = v;
    tick16 = 1'b0;
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  function automatic int nbits();
    return int'(cfg_wlen) + 5;
  endfunction

  function automatic int flen();
    return nbits() + int'(cfg_par_en) + 1 + int'(cfg_two_stop);
  endfunction

  task automatic set_bit(input int i, input bit v);
    hcnt[i] = v ? 15 : 0;
    s15[i]  = 1'($urandom_range(0, 1));
  endtask

  // clean frame carrying d with correct parity and high stop bits
  task automatic build(input logic [7:0] d);
    bit p = cfg_par_odd;
    for (int i = 0; i < nbits(); i++) begin
      set_bit(i, d[i]);
      p ^= d[i];
    end
    if (cfg_par_en) set_bit(nbits(), p);
    for (int i = nbits() + int'(cfg_par_en); i < flen(); i++) set_bit(i, 1'b1);
  endtask

  task automatic send_and_check(input string tag);
    int nb = nbits();
    logic [7:0] ed = '0;
    logic [8:0] em = '0;
    int flags = 0;
    bit x = 1'b0;
    bit ep = 1'b0, ec = 1'b0, ef = 1'b0;
    int v0;
    for (int i = 0; i < nb; i++) begin
      ed[i] = (hcnt[i] >= 8);
      em[i] = (hcnt[i] >= 6) && (hcnt[i] <= 9);
      x ^= ed[i];
      flags += int'(em[i]);
    end
    if (cfg_par_en) begin
      em[8] = (hcnt[nb] >= 6) && (hcnt[nb] <= 9);
      x ^= (hcnt[nb] >= 8);
      flags += int'(em[8]);
      if (x != cfg_par_odd) begin
        if (flags == 1) begin
          ec = 1'b1;
          if (!em[8]) ed = ed ^ em[7:0];
        end else begin
          ep = 1'b1;
        end
      end
    end
    for (int i = nb + int'(cfg_par_en); i < flen(); i++)
      if (hcnt[i] < 8) ef = 1'b1;
    v0 = vcount;
    repeat (3) tk(1'b1);
    repeat (16) tk(1'b0);
    for (int i = 0; i < flen(); i++) begin
      for (int s = 0; s < 15; s++) tk(s < hcnt[i]);
      tk(s15[i]);
    end
    check("R8", {tag, " strobe"}, int'(rx_valid), 1);
    check("R4", {tag, " data"}, int'(rx_data), int'(ed));
    check("R3", {tag, " mask"}, int'(q_mask), int'(em));
    check("R5", {tag, " parity_err"}, int'(parity_err), int'(ep));
    check("R6", {tag, " corrected"}, int'(corrected), int'(ec));
    check("R7", {tag, " frame_err"}, int'(frame_err), int'(ef));
    @(negedge clk);
    check("R8", {tag, " strobe width"}, int'(rx_valid), 0);
    check("R8", {tag, " strobe count"}, vcount, v0 + 1);
    check("R8", {tag, " hold data"}, int'(rx_data), int'(ed));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "data", int'(rx_data), 0);
    check("R9", "valid", int'(rx_valid), 0);
    check("R9", "flags", int'({frame_err, parity_err, corrected}), 0);
    check("R9", "mask", int'(q_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 false start: line returns high before the 8th tick
    v0 = vcount;
    repeat (3) tk(1'b1);
    repeat (5) tk(1'b0);
    repeat (40) tk(1'b1);
    check("R1", "false start strobe", vcount, v0);

    // R1/R4 clean 8N1 after the false start
    cfg_wlen = 2'b11; cfg_par_en = 0; cfg_two_stop = 0;
    build(8'hA5);
    send_and_check("R1 clean 8N1");

    // R2 thresholds: 8 -> 1, 7 with high 16th sample -> 0, 10 and 5 unflagged
    build(8'h00);
    hcnt[0] = 8;
    hcnt[1] = 7; s15[1] = 1'b1;
    hcnt[2] = 10;
    hcnt[3] = 5;
    hcnt[4] = 15;
    send_and_check("R2 thresholds");

    // R4 five-bit word right aligned
    cfg_wlen = 2'b00;
    build(8'h1B);
    send_and_check("R4 five bit");

    // R6 single flagged data bit, even parity
    cfg_wlen = 2'b11; cfg_par_en = 1; cfg_par_odd = 0;
    build(8'h3C);
    hcnt[2] = 7;
    send_and_check("R6 data repair");

    // R6 flagged parity bit, odd parity, 7 bits
    cfg_wlen = 2'b10; cfg_par_odd = 1;
    build(8'h55);
    hcnt[7] = (hcnt[7] >= 8) ? 6 : 9;
    send_and_check("R6 parity repair");

    // R5 two flagged bits, check fails
    cfg_wlen = 2'b11; cfg_par_odd = 0;
    build(8'h81);
    hcnt[0] = 7;
    hcnt[5] = 6;
    send_and_check("R5 two flags");

    // R5 parity failure with no flag
    build(8'h12);
    hcnt[3] = 15;
    send_and_check("R5 no flag");

    // R7 second stop bit low
    cfg_two_stop = 1;
    build(8'hC3);
    hcnt[10] = 2;
    send_and_check("R7 second stop");

    // R7 single stop low, 6 bits
    cfg_two_stop = 0; cfg_par_en = 0; cfg_wlen = 2'b01;
    build(8'h2A);
    hcnt[6] = 0;
    send_and_check("R7 stop low");

    // random frames
    for (int f = 0; f < 60; f++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cfg_wlen     = 2'($urandom_range(0, 3));
      cfg_par_en   = 1'($urandom_range(0, 1));
      cfg_par_odd  = 1'($urandom_range(0, 1));
      cfg_two_stop = 1'($urandom_range(0, 1));
      build(d);
      for (int i = 0; i < nbits() + int'(cfg_par_en); i++) begin
        if ($urandom_range(0, 5) == 0) hcnt[i] = $urandom_range(6, 9);
        else if (hcnt[i] >= 8)         hcnt[i] = $urandom_range(10, 15);
        else                           hcnt[i] = $urandom_range(0, 5);
      end
      for (int i = nbits() + int'(cfg_par_en); i < flen(); i++)
        hcnt[i] = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : $urandom_range(10, 15);
      send_and_check("R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule